// File: doc/BRIEF.md
# Bus-Conflict Program Bank Mapper

This block is the address-mapping controller of a cartridge that sits on an 8-bit CPU bus. The program ROM is divided into 16 KB banks. A CPU read in 0xC000–0xFFFF always reaches the highest bank of the ROM. A CPU read in 0x8000–0xBFFF reaches the bank held in a 4-bit select register. Any CPU write in 0x8000–0xFFFF reloads that register. The written byte is first ANDed with the ROM byte that is driven onto the bus at the same address, which models the bus conflict of a ROM that does not turn off its outputs during a write. The bank number is then taken from bits 5:2 of the result.

The block also holds a small character RAM on the video-side bus, which a loader can preload at startup and which can be rewritten afterwards. A constant output tells the nametable logic to use vertical mirroring. A restore port loads the select register straight from saved state, with no bus-conflict step. The ROM array is outside the block. It receives `prg_rom_addr` and returns `prg_rom_data` combinationally.

Top module: `bank_map_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first loading write after it rises, the select register holds 0. The switchable window therefore shows bank 0 and the fixed window shows bank `NUM_BANKS-1`.
- R2: When `cpu_addr[15:14]` is 2'b11, `prg_rom_addr` equals `{NUM_BANKS-1, cpu_addr[13:0]}`, whatever the register holds.
- R3: When `cpu_addr[15:14]` is 2'b10, `prg_rom_addr` equals `{bank, cpu_addr[13:0]}`, where bank is the select register taken modulo `NUM_BANKS`.
- R4: A clock edge with `cpu_we` high and `cpu_addr[15]` high loads the register with bits 5:2 of `cpu_wdata & prg_rom_data`. No other address bits are decoded. The new mapping appears in the cycle after that edge.
- R5: Bits 7, 6, 1 and 0 of the conflicted byte do not affect the bank. With ROM byte 0xFF, the values 0x08, 0x88 and 0xCB all select bank 2.
- R6: A write with `cpu_addr[15]` low leaves the register unchanged.
- R7: A clock edge with `restore_we` high loads `restore_bank` into the register unmodified. If a CPU write to 0x8000–0xFFFF occurs in the same cycle, the restore wins.
- R8: `cpu_rdata` equals `prg_rom_data` when `cpu_addr[15]` is high. It is 0x00 otherwise, because the block has no program RAM.
- R9: The character RAM holds 2^`CHR_AW` bytes (8 KB with `CHR_AW`=13). A clock edge with `ppu_we` high stores `ppu_wdata` at `ppu_addr`. `ppu_rdata` shows the byte at `ppu_addr` combinationally, so bytes written by the preload are read back unchanged.
- R10: `mirror_vertical` is always 1. No register write, restore or reset changes it.
- R11: A register value at or above `NUM_BANKS` wraps modulo `NUM_BANKS` when the address is formed. With 13 banks, 13 selects bank 0 and 15 selects bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | CPU read data |
| prg_rom_addr | output | ROM_AW | Byte address into the program ROM |
| prg_rom_data | input | 8 | ROM byte at `prg_rom_addr` |
| ppu_addr | input | CHR_AW | Character RAM address |
| ppu_wdata | input | 8 | Character RAM write data |
| ppu_we | input | 1 | Character RAM write strobe |
| ppu_rdata | output | 8 | Character RAM read data |
| restore_we | input | 1 | Load the register from saved state |
| restore_bank | input | 4 | Saved register value |
| mirror_vertical | output | 1 | Constant 1: vertical nametable mirroring |

## Verification
The bench writes bytes whose ROM partner is not 0xFF, so the AND step matters. A design that extracted the bank before the AND, or that used the low bits of the byte, selects the wrong bank. Writes land in both windows and below 0x8000. This catches decoding that is too narrow, too broad or missing. Register values 13 to 15 check the wrap of an odd-sized ROM, where a truncating design would point past the end of the ROM. A restore issued in the same cycle as a CPU write shows whether the restore wins and whether it skips the AND.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int SEL_W     = 4;
    localparam int WIN_OFF_W = 14;
    localparam int SEL_LSB   = 2;
    localparam int DATA_W    = 8;
    localparam int CPU_AW    = 16;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        LOAD_NONE    = 2'd0,
        LOAD_CPU     = 2'd1,
        LOAD_RESTORE = 2'd2
    } load_src_e;
endpackage

// File: rtl/prg_bank_latch.sv
module prg_bank_latch
    import bank_map_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cpu_we,
    input  logic  cpu_hi,
    input  byte_t cpu_wdata,
    input  byte_t rom_byte,
    input  logic  restore_we,
    input  sel_t  restore_bank,
    output sel_t  bank_q
);
    load_src_e src;
    byte_t     conflicted;

    assign conflicted = cpu_wdata & rom_byte;

    always_comb begin
        if (restore_we)           src = LOAD_RESTORE;
        else if (cpu_we && cpu_hi) src = LOAD_CPU;
        else                       src = LOAD_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            unique case (src)
                LOAD_RESTORE: bank_q <= restore_bank;
                LOAD_CPU:     bank_q <= conflicted[SEL_LSB +: SEL_W];
                default:      bank_q <= bank_q;
            endcase
        end
    end
endmodule

// File: rtl/prg_addr_xlate.sv
module prg_addr_xlate
    import bank_map_pkg::*;
#(
    parameter int NUM_BANKS = 13,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ROM_AW   = IDX_W + WIN_OFF_W
)(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  sel_t              bank_q,
    output logic [ROM_AW-1:0] rom_addr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);
    localparam bit IS_POW2 = (NUM_BANKS & (NUM_BANKS - 1)) == 0;

    logic [IDX_W-1:0] sw_idx;
    logic [IDX_W-1:0] win_idx;

    generate
        if (IS_POW2) begin : g_mask
            assign sw_idx = IDX_W'(32'(bank_q) & (NUM_BANKS - 1));
        end else begin : g_mod
            assign sw_idx = IDX_W'(32'(bank_q) % NUM_BANKS);
        end
    endgenerate

    assign win_idx  = cpu_addr[WIN_OFF_W] ? LAST_IDX : sw_idx;
    assign rom_addr = {win_idx, cpu_addr[WIN_OFF_W-1:0]};
endmodule

// File: rtl/chr_store.sv
module chr_store
    import bank_map_pkg::*;
#(
    parameter int CHR_AW = 11,
    localparam int DEPTH = 1 << CHR_AW
)(
    input  logic              clk,
    input  logic [CHR_AW-1:0] addr,
    input  byte_t             wdata,
    input  logic              we,
    output byte_t             rdata
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bank_map_pkg::*;
#(
    parameter int NUM_BANKS = 13,
    parameter int CHR_AW    = 11,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ROM_AW   = IDX_W + WIN_OFF_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] prg_rom_addr,
    input  logic [7:0]        prg_rom_data,
    input  logic [CHR_AW-1:0] ppu_addr,
    input  logic [7:0]        ppu_wdata,
    input  logic              ppu_we,
    output logic [7:0]        ppu_rdata,
    input  logic              restore_we,
    input  logic [3:0]        restore_bank,
    output logic              mirror_vertical
);
    sel_t bank_q;
    logic cpu_hi;

    assign cpu_hi = cpu_addr[CPU_AW-1];

    prg_bank_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_we       (cpu_we),
        .cpu_hi       (cpu_hi),
        .cpu_wdata    (cpu_wdata),
        .rom_byte     (prg_rom_data),
        .restore_we   (restore_we),
        .restore_bank (restore_bank),
        .bank_q       (bank_q)
    );

    prg_addr_xlate #(.NUM_BANKS(NUM_BANKS)) u_xlate (
        .cpu_addr (cpu_addr),
        .bank_q   (bank_q),
        .rom_addr (prg_rom_addr)
    );

    chr_store #(.CHR_AW(CHR_AW)) u_chr (
        .clk   (clk),
        .addr  (ppu_addr),
        .wdata (ppu_wdata),
        .we    (ppu_we),
        .rdata (ppu_rdata)
    );

    assign cpu_rdata       = cpu_hi ? prg_rom_data : 8'h00;
    assign mirror_vertical = 1'b1;
endmodule

// File: rtl/bank_map_ctrl_chk.sv
module bank_map_ctrl_chk #(
    parameter int NUM_BANKS = 13,
    parameter int ROM_AW    = 18
)(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_we,
    input logic [7:0]        prg_rom_data,
    input logic [ROM_AW-1:0] prg_rom_addr,
    input logic              restore_we,
    input logic [3:0]        restore_bank,
    input logic [3:0]        bank_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> bank_q == 4'd0); // R1

    AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:14] == 2'b11 |-> 32'(prg_rom_addr >> 14) == NUM_BANKS - 1); // R2

    AST_WINDOW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(prg_rom_addr >> 14) < NUM_BANKS); // R11

    AST_CONFLICT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we && cpu_addr[15] && !restore_we |=>
            bank_q == $past(4'((cpu_wdata & prg_rom_data) >> 2))); // R4

    AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[15] && !restore_we |=> $stable(bank_q)); // R6

    AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we |=> bank_q == $past(restore_bank)); // R7
endmodule

bind bank_map_ctrl bank_map_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ROM_AW(ROM_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_we       (cpu_we),
    .prg_rom_data (prg_rom_data),
    .prg_rom_addr (prg_rom_addr),
    .restore_we   (restore_we),
    .restore_bank (restore_bank),
    .bank_q       (bank_q)
);

// File: tb/sim_bank_map_ctrl.sv
`timescale 1ns/1ps
module sim_bank_map_ctrl;
    localparam int NB     = 13;
    localparam int CAW    = 11;
    localparam int RAW    = $clog2(NB) + 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = '0;
    logic [7:0]     cpu_wdata = '0;
    logic           cpu_we = 1'b0;
    logic [7:0]     cpu_rdata;
    logic [RAW-1:0] prg_rom_addr;
    logic [7:0]     prg_rom_data;
    logic [CAW-1:0] ppu_addr = '0;
    logic [7:0]     ppu_wdata = '0;
    logic           ppu_we = 1'b0;
    logic [7:0]     ppu_rdata;
    logic           restore_we = 1'b0;
    logic [3:0]     restore_bank = '0;
    logic           mirror_vertical;

    int checks = 0;
    int errors = 0;
    int m_bank = 0;
    int chr_val [int];
    bit done = 1'b0;

    always #4 clk = ~clk;

    // ROM contents: 0xFF in the top quarter of every bank, a mixed pattern elsewhere
    function automatic int rom_byte(int a);
        if ((a & 'h3000) == 'h3000) return 'hFF;
        return (a ^ (a >> 10) ^ 'h5A) & 'hFF;
    endfunction

    assign prg_rom_data = 8'(rom_byte(int'(prg_rom_addr)));

    bank_map_ctrl #(.NUM_BANKS(NB), .CHR_AW(CAW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .prg_rom_addr(prg_rom_addr),
        .prg_rom_data(prg_rom_data), .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata),
        .ppu_we(ppu_we), .ppu_rdata(ppu_rdata), .restore_we(restore_we),
        .restore_bank(restore_bank), .mirror_vertical(mirror_vertical)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rom_addr();
        int win;
        win = cpu_addr[14] ? NB - 1 : m_bank % NB;
        return win * 16384 + int'(cpu_addr[13:0]);
    endfunction

    // one cycle: inputs already driven after a falling edge
    task automatic tick(string req);
        int ea;
        #1;
        ea = exp_rom_addr();
        if (cpu_addr[15]) chk(req, int'(prg_rom_addr), ea);
        chk({req, " R8 rdata"}, int'(cpu_rdata), cpu_addr[15] ? rom_byte(ea) : 0);
        chk("R10 mirror", int'(mirror_vertical), 1);
        if (chr_val.exists(int'(ppu_addr)) && !ppu_we)
            chk("R9 chr read", int'(ppu_rdata), chr_val[int'(ppu_addr)]);
        @(posedge clk);
        if (!rst_n) m_bank = 0;
        else if (restore_we) m_bank = int'(restore_bank);
        else if (cpu_we && cpu_addr[15]) m_bank = ((int'(cpu_wdata) & rom_byte(ea)) >> 2) & 15;
        if (ppu_we) chr_val[int'(ppu_addr)] = int'(ppu_wdata);
        @(negedge clk);
        cpu_we = 1'b0; restore_we = 1'b0; ppu_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, string req);
        cpu_addr = a; tick(req);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string req);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; tick(req);
    endtask

    initial begin
        @(negedge clk);
        rd(16'h8123, "R1 reset low window");
        rd(16'h8123, "R1 reset low window");
        rst_n = 1'b1;
        rd(16'h8123, "R1 after reset low window");
        rd(16'hC123, "R1 R2 after reset fixed window");
        // top-quarter addresses carry ROM byte 0xFF, so the value passes untouched
        wr(16'hB000, 8'h04, "R4 load bank 1");
        rd(16'h8123, "R3 bank 1 visible");
        wr(16'hB456, 8'h88, "R5 0x88 selects 2");
        rd(16'h8ABC, "R5 bank 2 visible");
        wr(16'hB000, 8'hCB, "R5 0xCB selects 2");
        rd(16'h9FFF, "R5 bank 2 again");
        wr(16'hF000, 8'h18, "R4 write in fixed window");
        rd(16'h8123, "R4 bank 6 visible");
        rd(16'hC123, "R2 fixed window unaffected");
        rd(16'hFFFF, "R2 fixed window top");
        // conflict: ROM byte is not 0xFF at these offsets
        wr(16'h8001, 8'h3C, "R4 conflicted write");
        rd(16'h8123, "R4 conflicted bank visible");
        wr(16'hC055, 8'hFF, "R4 conflicted write fixed");
        rd(16'hA123, "R4 conflicted bank visible");
        wr(16'hB000, 8'h1C, "R4 load bank 7");
        wr(16'h7000, 8'h3C, "R6 low write");
        rd(16'h8123, "R6 bank 7 kept");
        wr(16'h0000, 8'h04, "R6 low write zero page");
        rd(16'h8123, "R6 bank 7 kept");
        rd(16'h1234, "R8 low read");
        restore_we = 1'b1; restore_bank = 4'd9;
        rd(16'h8000, "R7 restore 9");
        rd(16'h8123, "R7 bank 9 visible");
        restore_we = 1'b1; restore_bank = 4'd3;
        wr(16'hB000, 8'h3C, "R7 restore beats write");
        rd(16'h8123, "R7 bank 3 visible");
        restore_we = 1'b1; restore_bank = 4'd14;
        rd(16'h8000, "R7 restore raw 14");
        rd(16'h8123, "R11 14 wraps to 1");
        wr(16'hB000, 8'h34, "R11 load 13");
        rd(16'h8123, "R11 13 wraps to 0");
        wr(16'hB000, 8'h3C, "R11 load 15");
        rd(16'hBFFF, "R11 15 wraps to 2");
        // character RAM preload then reads and an overwrite
        for (int i = 0; i < 8; i++) begin
            ppu_addr = CAW'(i * 97 + 3); ppu_wdata = 8'(i * 29 + 1); ppu_we = 1'b1;
            rd(16'h8000, "R9 preload");
        end
        for (int i = 0; i < 8; i++) begin
            ppu_addr = CAW'(i * 97 + 3);
            rd(16'hC000, "R9 readback");
        end
        ppu_addr = CAW'(100); ppu_wdata = 8'hC7; ppu_we = 1'b1;
        rd(16'h8000, "R9 overwrite");
        rd(16'h8000, "R9 overwrite readback");
        ppu_addr = '1; ppu_wdata = 8'h3A; ppu_we = 1'b1;
        rd(16'h8000, "R9 top byte");
        rd(16'h8000, "R9 top byte readback");
        rst_n = 1'b0;
        rd(16'h8123, "R1 second reset");
        rst_n = 1'b1;
        rd(16'h8123, "R1 bank 0 after second reset");
        rd(16'hC123, "R1 last bank after second reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule